// File: doc/BRIEF.md
# Emergency Stop Output Guard

This block sits between a multi-phase motor PWM generator and the output stage. It watches an external active-low emergency input. While the guard is armed, an active emergency level latches a protective state. In that state every phase output is forced to 0, and the state can be read back as a status bit. Software leaves the protective state by writing a return command, and only once the emergency input has gone inactive.

The guard comes out of reset armed. Software may disarm it only after writing a two-byte key, 0x5A and then 0xA5, to a write-only key register. A successful key allows exactly one control write. It can be re-armed at any time without a key. Access is through a small byte-wide register port. Address 0 is the control register. Address 1 is the key register.

Top module: `emg_guard`

## Requirements
- R1: After reset the guard is armed and not tripped. A read of address 0 returns 0x01, where bit 0 is the arm bit, bit 1 is the return command and always reads 0, and bit 2 is the tripped status.
- R2: The key register at address 1 is write-only, and every read of it returns 0x00.
- R3: While armed, a 0 on `emg_n` passes through a two-flop synchronizer. The status bit becomes 1 at the third rising edge after the input falls, and not before.
- R4: While the status bit is 1, all phase outputs are 0. Otherwise each phase output equals its phase input.
- R5: Writing address 0 with bit 1 set clears the status bit at that edge, provided the synchronized emergency input is inactive.
- R6: A return write is ignored while the synchronized emergency input is still active, and the status bit stays 1.
- R7: Writing 0 to the arm bit disarms the guard only if 0x5A and then 0xA5 were written to address 1 just before. Without that key the arm bit stays 1.
- R8: Any other key byte, including the right bytes in the wrong order, restarts the key tracker, and a following disarm write fails.
- R9: An unlocked key is used up by the next write to address 0, whatever the value written.
- R10: While disarmed, the emergency input is ignored. The status stays 0 and the phase outputs follow the phase inputs.
- R11: Writing 1 to the arm bit re-arms the guard without any key.
- R12: The status bit is read-only. Writing 1 to bit 2 neither sets it nor has any other effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select: 0 control, 1 key |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| emg_n | input | 1 | Asynchronous emergency input, active low |
| phase_in | input | 6 | Phase signals from the PWM generator |
| phase_out | output | 6 | Gated phase signals to the output stage |

## Verification
A register write takes effect at the rising edge on which `reg_we` is high, and the read data is combinational. The bench therefore drives each write for one cycle starting on a falling edge, and reads back on the next falling edge. The emergency path is three registers deep: two synchronizer flops and the state flop. After moving `emg_n` on a falling edge, the bench checks that the status is still 0 after one and two rising edges, and that it is 1 after the third. It checks `phase_out` in that same sample, because the gating is combinational from the state flop. A release of the input also needs two edges to pass the synchronizer, so the bench waits three cycles before it issues a return write.

// File: rtl/emg_pkg.sv
// Shared constants and types for the emergency stop output guard.
// Assumes byte-wide register access and a one-bit register address.
package emg_pkg;
    localparam int DW         = 8;
    localparam int BIT_ARM    = 0;   // control: arm
    localparam int BIT_RET    = 1;   // control: return command, reads 0
    localparam int BIT_STAT   = 2;   // control: tripped status, read-only
    localparam logic ADDR_CTRL = 1'b0;
    localparam logic ADDR_KEY  = 1'b1;

    typedef enum logic [1:0] {
        KEY_IDLE = 2'd0,
        KEY_HALF = 2'd1,
        KEY_OPEN = 2'd2
    } key_state_t;
endpackage

// File: rtl/emg_sync.sv
// Multi-stage synchronizer for the active-low emergency input.
// Assumes the input is asynchronous. It resets to the inactive (high) level.
module emg_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_n,
    output logic sync_n
);
    logic [STAGES-1:0] chain_q;

    // Shift the raw input through the flop chain.
    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (!rst_n) chain_q[0] <= 1'b1;
                    else        chain_q[0] <= async_n;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (!rst_n) chain_q[s] <= 1'b1;
                    else        chain_q[s] <= chain_q[s-1];
                end
            end
        end
    endgenerate

    assign sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/emg_unlock.sv
// Tracks the two-byte key written to the write-only key register.
// Assumes key_we and ctrl_we are never high together. An open key is
// used up by the next control write.
module emg_unlock
    import emg_pkg::*;
#(
    parameter logic [DW-1:0] KEY_A = 8'h5A,
    parameter logic [DW-1:0] KEY_B = 8'hA5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          key_we,
    input  logic [DW-1:0] key_data,
    input  logic          ctrl_we,
    output logic          open
);
    key_state_t state_q, state_d;

    // Next state: an ordered key match advances, anything else restarts.
    always_comb begin
        state_d = state_q;
        if (key_we) begin
            if (key_data == KEY_A)                          state_d = KEY_HALF;
            else if (key_data == KEY_B && state_q == KEY_HALF) state_d = KEY_OPEN;
            else                                            state_d = KEY_IDLE;
        end else if (ctrl_we && state_q == KEY_OPEN) begin
            state_d = KEY_IDLE;
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= KEY_IDLE;
        else        state_q <= state_d;
    end

    assign open = (state_q == KEY_OPEN);

    AST_OPEN_NEEDS_KEY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(open) |-> $past(key_we && key_data == KEY_B)); // R7
    AST_OPEN_USED_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        (open && ctrl_we) |=> !open); // R9
endmodule

// File: rtl/emg_trip.sv
// Protective-state latch and phase output gating.
// Assumes emg_act is already synchronized. Setting wins over a return request.
module emg_trip #(
    parameter int NPHASE = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arm,
    input  logic              emg_act,
    input  logic              ret_req,
    input  logic [NPHASE-1:0] phase_in,
    output logic              tripped,
    output logic [NPHASE-1:0] phase_out
);
    logic trip_q;

    // Latch on an armed emergency level; clear on return once the input is inactive.
    always_ff @(posedge clk) begin
        if (!rst_n)                 trip_q <= 1'b0;
        else if (arm && emg_act)    trip_q <= 1'b1;
        else if (ret_req && !emg_act) trip_q <= 1'b0;
    end

    // Force every phase inactive while tripped.
    generate
        for (genvar p = 0; p < NPHASE; p++) begin : g_gate
            assign phase_out[p] = phase_in[p] & ~trip_q;
        end
    endgenerate

    assign tripped = trip_q;

    AST_TRIP_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (arm && emg_act) |=> tripped); // R3
    AST_RET_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (tripped && emg_act) |=> tripped); // R6
    AST_PHASE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        tripped |-> (phase_out == '0)); // R4
endmodule

// File: rtl/emg_guard.sv
// Emergency stop output guard: register port, arm bit, key-gated disarm,
// synchronized emergency input and phase gating.
// Assumes one register access per cycle. Read data is combinational.
module emg_guard
    import emg_pkg::*;
#(
    parameter int NPHASE      = 6,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic              reg_addr,
    input  logic [DW-1:0]     reg_wdata,
    output logic [DW-1:0]     reg_rdata,
    input  logic              emg_n,
    input  logic [NPHASE-1:0] phase_in,
    output logic [NPHASE-1:0] phase_out
);
    logic ctrl_we, key_we, unlock_open, arm_q, emg_sync_n, tripped;

    assign ctrl_we = reg_we && (reg_addr == ADDR_CTRL);
    assign key_we  = reg_we && (reg_addr == ADDR_KEY);

    emg_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_n(emg_n), .sync_n(emg_sync_n)
    );

    emg_unlock u_unlock (
        .clk(clk), .rst_n(rst_n), .key_we(key_we), .key_data(reg_wdata),
        .ctrl_we(ctrl_we), .open(unlock_open)
    );

    // Arm bit: set freely, cleared only through an open key.
    always_ff @(posedge clk) begin
        if (!rst_n) arm_q <= 1'b1;
        else if (ctrl_we) begin
            if (reg_wdata[BIT_ARM]) arm_q <= 1'b1;
            else if (unlock_open)   arm_q <= 1'b0;
        end
    end

    emg_trip #(.NPHASE(NPHASE)) u_trip (
        .clk(clk), .rst_n(rst_n), .arm(arm_q), .emg_act(!emg_sync_n),
        .ret_req(ctrl_we && reg_wdata[BIT_RET]),
        .phase_in(phase_in), .tripped(tripped), .phase_out(phase_out)
    );

    // Read mux: the key register always reads zero.
    always_comb begin
        reg_rdata = '0;
        if (reg_addr == ADDR_CTRL) begin
            reg_rdata[BIT_ARM]  = arm_q;
            reg_rdata[BIT_STAT] = tripped;
        end
    end

    AST_DISARM_KEYED: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(arm_q) |-> $past(unlock_open)); // R7
    AST_KEY_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == ADDR_KEY) |-> (reg_rdata == '0)); // R2
    AST_DISARMED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!arm_q && !tripped) |=> !tripped); // R10
endmodule

// File: tb/test_emg_guard.sv
`timescale 1ns/1ps
module test_emg_guard;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_we = 1'b0;
    logic       reg_addr = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       emg_n = 1'b1;
    logic [5:0] phase_in = 6'h2A;
    logic [5:0] phase_out;
    int total = 0;
    int fails = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    emg_guard i_emg_guard (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .emg_n(emg_n),
        .phase_in(phase_in), .phase_out(phase_out)
    );

    // Step: {we, addr, wdata, expected control read after the step}
    localparam int NSTEP = 19;
    localparam logic [17:0] STEPS [NSTEP] = '{
        {1'b0, 1'b0, 8'h00, 8'h01},   // R1 reset value
        {1'b1, 1'b0, 8'h00, 8'h01},   // R7 disarm without key fails
        {1'b1, 1'b1, 8'h5A, 8'h01},
        {1'b1, 1'b1, 8'h00, 8'h01},   // R8 broken key
        {1'b1, 1'b1, 8'hA5, 8'h01},
        {1'b1, 1'b0, 8'h00, 8'h01},
        {1'b1, 1'b1, 8'hA5, 8'h01},   // R8 wrong order
        {1'b1, 1'b1, 8'h5A, 8'h01},
        {1'b1, 1'b0, 8'h00, 8'h01},
        {1'b1, 1'b1, 8'h5A, 8'h01},   // R7 good key
        {1'b1, 1'b1, 8'hA5, 8'h01},
        {1'b1, 1'b0, 8'h00, 8'h00},
        {1'b1, 1'b0, 8'h01, 8'h01},   // R11 re-arm, no key
        {1'b1, 1'b0, 8'h00, 8'h01},   // R9 key already used
        {1'b1, 1'b1, 8'h5A, 8'h01},
        {1'b1, 1'b1, 8'hA5, 8'h01},
        {1'b1, 1'b0, 8'h01, 8'h01},   // R9 any control write uses key
        {1'b1, 1'b0, 8'h00, 8'h01},
        {1'b1, 1'b0, 8'h04, 8'h01}    // R12 status not writable
    };

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic a, output logic [7:0] d);
        reg_addr = a;
        #0.5;
        d = reg_rdata;
    endtask

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        for (int i = 0; i < NSTEP; i++) begin
            if (STEPS[i][17]) wr(STEPS[i][16], STEPS[i][15:8]);
            rd(1'b0, v);
            chk($sformatf("table step %0d (R1 R7 R8 R9 R11 R12)", i), v, STEPS[i][7:0]);
        end
        // R2: key register reads zero even after a write
        wr(1'b1, 8'h5A);
        rd(1'b1, v);
        chk("R2 key read", v, 8'h00);
        // R4: pass-through while not tripped
        rd(1'b0, v);
        chk("R4 pass-through", {2'b00, phase_out}, 8'h2A);
        // R3: three edges from emergency to status
        @(negedge clk); emg_n = 1'b0;
        @(negedge clk); rd(1'b0, v); chk("R3 not after one edge", v, 8'h01);
        @(negedge clk); rd(1'b0, v); chk("R3 not after two edges", v, 8'h01);
        @(negedge clk); rd(1'b0, v); chk("R3 set after three edges", v, 8'h05);
        chk("R4 outputs forced", {2'b00, phase_out}, 8'h00);
        // R6: return ignored while input active
        wr(1'b0, 8'h03);
        rd(1'b0, v);
        chk("R6 return blocked", v, 8'h05);
        chk("R4 still forced", {2'b00, phase_out}, 8'h00);
        // R5: release, let synchronizer settle, then return
        emg_n = 1'b1;
        repeat (3) @(negedge clk);
        wr(1'b0, 8'h03);
        rd(1'b0, v);
        chk("R5 return clears", v, 8'h01);
        chk("R4 outputs restored", {2'b00, phase_out}, 8'h2A);
        phase_in = 6'h15;
        #0.5;
        chk("R4 new pattern", {2'b00, phase_out}, 8'h15);
        // R10: disarmed guard ignores the input
        wr(1'b1, 8'h5A);
        wr(1'b1, 8'hA5);
        wr(1'b0, 8'h00);
        emg_n = 1'b0;
        repeat (5) @(negedge clk);
        rd(1'b0, v);
        chk("R10 no trip while disarmed", v, 8'h00);
        chk("R10 outputs follow", {2'b00, phase_out}, 8'h15);
        emg_n = 1'b1;
        repeat (3) @(negedge clk);
        wr(1'b0, 8'h01);
        rd(1'b0, v);
        chk("R11 re-armed", v, 8'h01);
        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        #500000;
        if (!done) begin
            total++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end
endmodule